// File: doc/BRIEF.md
# Programmable Card Access Strobe Sequencer

This block produces the pin timing for a single memory or I/O access to a 16-bit PC card. Every interval is counted in system clocks. A request carries the address, the transfer direction, a memory-or-I/O flag and the write data. The request is taken only while the sequencer is idle. The block then walks through four phases, each with its own programmed length: address setup, strobe setup, strobe active and strobe hold. It drives the card address, chip enable, register select, one of four access strobes and the data-bus enable. On a read it captures the card data. A one-cycle done pulse marks the end of the access.

The four phase lengths come in on configuration inputs and are sampled when the request is accepted, so they can change between accesses without disturbing an access in flight. A phase programmed to zero still lasts one clock. Only one strobe is used per access: output enable for memory reads, write enable for memory writes, I/O read or I/O write for I/O accesses.

Top module: `card_strobe_seq`

## Requirements
- R1: Out of reset the block is idle. busy and done are 0, card_addr is 0, card_data_oe is 0, and card_ce_n, card_reg_n and all four strobes are high.
- R2: When a request is accepted at clock edge P0, busy is 1 for exactly A+S+L+H cycles after P0. The phases run in order: A cycles of address setup, S of strobe setup, L of strobe active and H of hold. Each of A, S, L and H is the programmed count, or 1 when the count is zero.
- R3: A zero count in any phase gives that phase exactly one clock. All four counts at zero give a four-cycle access.
- R4: card_addr equals the accepted address in every busy cycle and is 0 while idle.
- R5: card_ce_n is low in exactly the strobe-setup and strobe-active cycles. card_reg_n is low in those same cycles for I/O accesses only.
- R6: Only during strobe-active cycles is one strobe low, chosen by {io,write}: 00 card_oe_n, 01 card_we_n, 10 card_iord_n, 11 card_iowr_n. At no time is more than one strobe low.
- R7: For memory and I/O writes, card_data_oe is 1 from the first strobe-setup cycle through the last hold cycle (from chip enable going active), and card_data_out then equals the accepted write data.
- R8: For reads, card_data_oe stays 0 for the whole access.
- R9: On a read, rd_data takes the value of card_data_in sampled at the clock edge that ends the last strobe-active cycle. rd_data is left unchanged by writes and between accesses.
- R10: done is 1 for exactly the one cycle after the last hold cycle, and busy is then 0.
- R11: Requests and configuration changes while busy are ignored. The address, data, direction, type and the four counts are those present at the acceptance edge.
- R12: A request presented during the done cycle is accepted, and its address setup starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | ADDR_W | Card address |
| req_wdata | input | DATA_W | Write data |
| cfg_addr_setup | input | AS_W | Address setup length in clocks |
| cfg_strb_setup | input | SS_W | Strobe setup length in clocks |
| cfg_strb_len | input | SL_W | Strobe active length in clocks |
| cfg_strb_hold | input | SH_W | Strobe hold length in clocks |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DATA_W | Captured read data |
| card_addr | output | ADDR_W | Address pins |
| card_ce_n | output | 1 | Chip enable, active low |
| card_reg_n | output | 1 | Register select, active low |
| card_oe_n | output | 1 | Memory output enable, active low |
| card_we_n | output | 1 | Memory write enable, active low |
| card_iord_n | output | 1 | I/O read strobe, active low |
| card_iowr_n | output | 1 | I/O write strobe, active low |
| card_data_oe | output | 1 | Data bus drive enable |
| card_data_out | output | DATA_W | Data driven to the card |
| card_data_in | input | DATA_W | Data returned by the card |

## Verification
The done pulse of one access and the acceptance of the next request can fall in the same cycle. The bench provokes this by presenting a fresh request, with new counts, at the done cycle of about half the random accesses. It then judges every following cycle against a phase model that starts the next address setup at once, while it still checks the done level and the read capture of the access that just ended. A second overlap is a request arriving while busy: random requests and configuration values are toggled during every access, and each pin is compared cycle by cycle against the values latched at acceptance.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ASU  = 3'd1,
      PH_SSU  = 3'd2,
      PH_STB  = 3'd3,
      PH_HLD  = 3'd4
   } cseq_phase_e;

   // strobe slot index, selected by {io, write}
   localparam int STB_MEM_RD = 0;
   localparam int STB_MEM_WR = 1;
   localparam int STB_IO_RD  = 2;
   localparam int STB_IO_WR  = 3;
   localparam int STB_NUM    = 4;
endpackage

// File: rtl/cseq_timer.sv
module cseq_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         // a programmed N lasts N clocks; zero is stretched to one
         cnt_q <= (load_val == '0) ? '0 : load_val - CNT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/cseq_pin_map.sv
module cseq_pin_map
   import cseq_pkg::*;
(
   input  cseq_phase_e        phase,
   input  logic               write,
   input  logic               io,
   output logic               ce_n,
   output logic               reg_n,
   output logic [STB_NUM-1:0] stb_n,
   output logic               data_oe
);
   logic       sel_win;
   logic [1:0] kind;

   assign sel_win = (phase == PH_SSU) || (phase == PH_STB);
   assign kind    = {io, write};
   assign ce_n    = !sel_win;
   assign reg_n   = !(sel_win && io);
   assign data_oe = write && ((phase == PH_SSU) || (phase == PH_STB) || (phase == PH_HLD));

   for (genvar k = 0; k < STB_NUM; k++) begin : g_stb
      assign stb_n[k] = !((phase == PH_STB) && (kind == 2'(k)));
   end
endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq
   import cseq_pkg::*;
#(
   parameter int ADDR_W = 26,
   parameter int DATA_W = 16,
   parameter int AS_W   = 4,
   parameter int SS_W   = 4,
   parameter int SL_W   = 6,
   parameter int SH_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [AS_W-1:0]   cfg_addr_setup,
   input  logic [SS_W-1:0]   cfg_strb_setup,
   input  logic [SL_W-1:0]   cfg_strb_len,
   input  logic [SH_W-1:0]   cfg_strb_hold,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] card_addr,
   output logic              card_ce_n,
   output logic              card_reg_n,
   output logic              card_oe_n,
   output logic              card_we_n,
   output logic              card_iord_n,
   output logic              card_iowr_n,
   output logic              card_data_oe,
   output logic [DATA_W-1:0] card_data_out,
   input  logic [DATA_W-1:0] card_data_in
);
   localparam int W_AB  = (AS_W > SS_W) ? AS_W : SS_W;
   localparam int W_CD  = (SL_W > SH_W) ? SL_W : SH_W;
   localparam int CNT_W = (W_AB > W_CD) ? W_AB : W_CD;

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
      $error("card_strobe_seq: bus widths must be positive");
   end
   if (AS_W < 1 || SS_W < 1 || SL_W < 1 || SH_W < 1) begin : g_bad_cnt
      $error("card_strobe_seq: phase count widths must be positive");
   end

   cseq_phase_e       ph_q, ph_nxt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              write_q, io_q;
   logic [SS_W-1:0]   ss_q;
   logic [SL_W-1:0]   sl_q;
   logic [SH_W-1:0]   sh_q;
   logic              done_q;
   logic [DATA_W-1:0] rd_q;
   logic              tmr_load, tmr_last;
   logic [CNT_W-1:0]  ld_val;
   logic              accept;
   logic [STB_NUM-1:0] stb_n;
   logic              data_oe;

   assign accept = (ph_q == PH_IDLE) && req_valid;

   always_comb begin
      tmr_load = 1'b0;
      ld_val   = '0;
      ph_nxt   = ph_q;
      unique case (ph_q)
         PH_IDLE: if (req_valid) begin
            tmr_load = 1'b1;
            ld_val   = CNT_W'(cfg_addr_setup);
            ph_nxt   = PH_ASU;
         end
         PH_ASU: if (tmr_last) begin
            tmr_load = 1'b1;
            ld_val   = CNT_W'(ss_q);
            ph_nxt   = PH_SSU;
         end
         PH_SSU: if (tmr_last) begin
            tmr_load = 1'b1;
            ld_val   = CNT_W'(sl_q);
            ph_nxt   = PH_STB;
         end
         PH_STB: if (tmr_last) begin
            tmr_load = 1'b1;
            ld_val   = CNT_W'(sh_q);
            ph_nxt   = PH_HLD;
         end
         PH_HLD: if (tmr_last) begin
            ph_nxt   = PH_IDLE;
         end
         default: ph_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         write_q <= 1'b0;
         io_q    <= 1'b0;
         ss_q    <= '0;
         sl_q    <= '0;
         sh_q    <= '0;
         done_q  <= 1'b0;
         rd_q    <= '0;
      end else begin
         ph_q   <= ph_nxt;
         done_q <= (ph_q == PH_HLD) && tmr_last;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            io_q    <= req_io;
            ss_q    <= cfg_strb_setup;
            sl_q    <= cfg_strb_len;
            sh_q    <= cfg_strb_hold;
         end
         if ((ph_q == PH_STB) && tmr_last && !write_q) begin
            rd_q <= card_data_in;
         end
      end
   end

   cseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (ld_val),
      .last     (tmr_last)
   );

   cseq_pin_map u_pins (
      .phase   (ph_q),
      .write   (write_q),
      .io      (io_q),
      .ce_n    (card_ce_n),
      .reg_n   (card_reg_n),
      .stb_n   (stb_n),
      .data_oe (data_oe)
   );

   assign busy          = (ph_q != PH_IDLE);
   assign done          = done_q;
   assign rd_data       = rd_q;
   assign card_addr     = busy ? addr_q : '0;
   assign card_oe_n     = stb_n[STB_MEM_RD];
   assign card_we_n     = stb_n[STB_MEM_WR];
   assign card_iord_n   = stb_n[STB_IO_RD];
   assign card_iowr_n   = stb_n[STB_IO_WR];
   assign card_data_oe  = data_oe;
   assign card_data_out = data_oe ? wdata_q : '0;
endmodule

// File: rtl/card_strobe_seq_chk.sv
module card_strobe_seq_chk #(
   parameter int ADDR_W = 26,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] card_addr,
   input logic              card_ce_n,
   input logic              card_reg_n,
   input logic              card_oe_n,
   input logic              card_we_n,
   input logic              card_iord_n,
   input logic              card_iowr_n,
   input logic              card_data_oe,
   input logic [DATA_W-1:0] card_data_out
);
   logic [3:0] stb_act;
   assign stb_act = ~{card_iowr_n, card_iord_n, card_we_n, card_oe_n};

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(stb_act) <= 1); // R6
   AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_act != 4'b0) |-> !card_ce_n); // R5
   AST_REG_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !card_reg_n |-> !card_ce_n); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy)); // R10
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(card_addr)); // R4
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (card_data_oe && $past(card_data_oe)) |-> $stable(card_data_out)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (card_ce_n && card_reg_n && stb_act == 4'b0 && !card_data_oe)); // R1
endmodule

bind card_strobe_seq card_strobe_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .done          (done),
   .card_addr     (card_addr),
   .card_ce_n     (card_ce_n),
   .card_reg_n    (card_reg_n),
   .card_oe_n     (card_oe_n),
   .card_we_n     (card_we_n),
   .card_iord_n   (card_iord_n),
   .card_iowr_n   (card_iowr_n),
   .card_data_oe  (card_data_oe),
   .card_data_out (card_data_out)
);

// File: tb/card_strobe_seq_tb.sv
module card_strobe_seq_tb;
   localparam int ADDR_W = 26;
   localparam int DATA_W = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid, req_write, req_io;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_wdata;
   logic [3:0]        cfg_addr_setup, cfg_strb_setup, cfg_strb_hold;
   logic [5:0]        cfg_strb_len;
   logic              busy, done;
   logic [DATA_W-1:0] rd_data;
   logic [ADDR_W-1:0] card_addr;
   logic              card_ce_n, card_reg_n, card_oe_n, card_we_n, card_iord_n, card_iowr_n;
   logic              card_data_oe;
   logic [DATA_W-1:0] card_data_out, card_data_in;

   int n_chk = 0;
   int n_bad = 0;
   logic [DATA_W-1:0] exp_rd = '0;
   int txn_id = 0;

   always #2 clk = ~clk;

   card_strobe_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
      .req_addr(req_addr), .req_wdata(req_wdata), .cfg_addr_setup(cfg_addr_setup),
      .cfg_strb_setup(cfg_strb_setup), .cfg_strb_len(cfg_strb_len), .cfg_strb_hold(cfg_strb_hold),
      .busy(busy), .done(done), .rd_data(rd_data), .card_addr(card_addr), .card_ce_n(card_ce_n),
      .card_reg_n(card_reg_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
      .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n), .card_data_oe(card_data_oe),
      .card_data_out(card_data_out), .card_data_in(card_data_in)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (txn %0d)", tag, act, exp, txn_id);
      end
   endtask

   function automatic int eff(input int n);
      return (n == 0) ? 1 : n;
   endfunction

   function automatic logic [DATA_W-1:0] card_val(input int c);
      return DATA_W'(c * 16'h0137) ^ DATA_W'(txn_id * 16'h2b01) ^ 16'ha5c3;
   endfunction

   function automatic logic [3:0] exp_stb(input bit in_stb, input logic io, input logic w);
      logic [3:0] v;
      v = 4'b1111;
      if (in_stb) v[{io, w}] = 1'b0;
      return v;
   endfunction

   task automatic idle_checks(input string why);
      chk(busy == 1'b0,          {why, " R1 busy"}, 32'(busy), 0);
      chk(card_addr == '0,       {why, " R4 addr idle"}, 32'(card_addr), 0);
      chk(card_ce_n && card_reg_n, {why, " R1 ce/reg"}, {30'b0, card_ce_n, card_reg_n}, 3);
      chk({card_iowr_n, card_iord_n, card_we_n, card_oe_n} == 4'hf, {why, " R1 strobes"},
          32'({card_iowr_n, card_iord_n, card_we_n, card_oe_n}), 32'hf);
      chk(card_data_oe == 1'b0,  {why, " R8 data_oe idle"}, 32'(card_data_oe), 0);
   endtask

   task automatic set_req(input logic w, input logic io, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input int as, input int ss, input int sl, input int sh);
      req_valid = 1'b1; req_write = w; req_io = io; req_addr = a; req_wdata = d;
      cfg_addr_setup = 4'(as); cfg_strb_setup = 4'(ss); cfg_strb_len = 6'(sl); cfg_strb_hold = 4'(sh);
   endtask

   // Called right after the negedge where the request was set up.
   task automatic run_txn(input logic w, input logic io, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input int as, input int ss, input int sl, input int sh);
      int A, S, L, H, T;
      A = eff(as); S = eff(ss); L = eff(sl); H = eff(sh); T = A + S + L + H;
      @(posedge clk);
      for (int c = 1; c <= T + 1; c++) begin
         bit in_ssu, in_stb, in_hld;
         @(negedge clk);
         in_ssu = (c > A) && (c <= A + S);
         in_stb = (c > A + S) && (c <= A + S + L);
         in_hld = (c > A + S + L) && (c <= T);
         if (c <= T) begin
            chk(busy == 1'b1, "R2 busy during access", 32'(busy), 1);
            chk(done == 1'b0, "R10 no done while busy", 32'(done), 0);
            chk(card_addr == a, "R4 address held", 32'(card_addr), 32'(a));
            chk(card_ce_n == !(in_ssu || in_stb), "R5 chip enable window", 32'(card_ce_n), 32'(!(in_ssu || in_stb)));
            chk(card_reg_n == !((in_ssu || in_stb) && io), "R5 register select", 32'(card_reg_n),
                32'(!((in_ssu || in_stb) && io)));
            chk({card_iowr_n, card_iord_n, card_we_n, card_oe_n} == exp_stb(in_stb, io, w), "R6 strobe select",
                32'({card_iowr_n, card_iord_n, card_we_n, card_oe_n}), 32'(exp_stb(in_stb, io, w)));
            if (w) begin
               chk(card_data_oe == (in_ssu || in_stb || in_hld), "R7 write data window",
                   32'(card_data_oe), 32'(in_ssu || in_stb || in_hld));
               if (card_data_oe) chk(card_data_out == d, "R7 write data value", 32'(card_data_out), 32'(d));
            end else begin
               chk(card_data_oe == 1'b0, "R8 no drive on read", 32'(card_data_oe), 0);
            end
            card_data_in = card_val(c);
            if (c == A + S + L && !w) exp_rd = card_val(c);
            // R11: noise that must be ignored while busy
            if (c < T) begin
               req_valid = 1'($urandom % 2); req_write = 1'($urandom); req_io = 1'($urandom);
               req_addr = ADDR_W'($urandom); req_wdata = DATA_W'($urandom);
               cfg_addr_setup = 4'($urandom); cfg_strb_setup = 4'($urandom);
               cfg_strb_len = 6'($urandom); cfg_strb_hold = 4'($urandom);
            end else begin
               req_valid = 1'b0;
            end
         end else begin
            chk(done == 1'b1, "R10 done after hold", 32'(done), 1);
            chk(rd_data == exp_rd, "R9 read capture", 32'(rd_data), 32'(exp_rd));
            idle_checks("done cycle");
         end
      end
      txn_id++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit b2b;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0; req_addr = '0; req_wdata = '0;
      cfg_addr_setup = '0; cfg_strb_setup = '0; cfg_strb_len = '0; cfg_strb_hold = '0; card_data_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle_checks("R1 reset");
      chk(done == 1'b0 && rd_data == '0, "R1 done/rd_data reset", {15'b0, done, rd_data}, 0);

      // R3: all-zero counts on each access kind
      for (int k = 0; k < 4; k++) begin
         set_req(1'(k), 1'(k >> 1), ADDR_W'(26'h155_0000 + k), DATA_W'(16'hbe00 + k), 0, 0, 0, 0);
         run_txn(1'(k), 1'(k >> 1), ADDR_W'(26'h155_0000 + k), DATA_W'(16'hbe00 + k), 0, 0, 0, 0);
         req_valid = 1'b0;
         @(negedge clk); idle_checks("R3 gap");
      end
      // R2: maximum counts, then a mixed one, back-to-back (R12)
      set_req(1'b0, 1'b0, 26'h3ff_ffff, 16'h0, 15, 15, 63, 15);
      run_txn(1'b0, 1'b0, 26'h3ff_ffff, 16'h0, 15, 15, 63, 15);
      set_req(1'b1, 1'b1, 26'h000_0001, 16'h5a5a, 1, 0, 2, 0);
      run_txn(1'b1, 1'b1, 26'h000_0001, 16'h5a5a, 1, 0, 2, 0);
      req_valid = 1'b0;

      b2b = 1'b0;
      for (int i = 0; i < 220; i++) begin
         logic w, io;
         logic [ADDR_W-1:0] a;
         logic [DATA_W-1:0] d;
         int as, ss, sl, sh;
         w = 1'($urandom); io = 1'($urandom); a = ADDR_W'($urandom); d = DATA_W'($urandom);
         as = ($urandom % 4 == 0) ? 0 : int'($urandom % 16);
         ss = ($urandom % 4 == 0) ? 0 : int'($urandom % 16);
         sl = ($urandom % 4 == 0) ? 0 : int'($urandom % 64);
         sh = ($urandom % 4 == 0) ? 0 : int'($urandom % 16);
         if (!b2b) begin
            req_valid = 1'b0;
            repeat (1 + $urandom % 3) begin
               @(negedge clk); idle_checks("R11 idle gap");
               chk(rd_data == exp_rd, "R9 rd_data held idle", 32'(rd_data), 32'(exp_rd));
            end
         end
         set_req(w, io, a, d, as, ss, sl, sh);
         run_txn(w, io, a, d, as, ss, sl, sh);
         b2b = 1'($urandom);
      end
      req_valid = 1'b0;
      @(negedge clk); idle_checks("final");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule